// File: doc/BRIEF.md
# Transfer Control and Status Register Unit

This block is the register front end of a disk DMA controller. It holds a small control register and a 32-bit status register, both reachable through a one-cycle CPU write strobe and a combinational read port selected by a single address bit. The transfer datapath reports events to it: command receipt, normal end, byte-counter overflow, buffer faults, write-check compare errors, drive exceptions, memory faults, map faults, nonexistent drives, corrected data and drive attention. The block turns these into transfer busy state, sticky error flags, an abort request, a controller clear pulse, a maintenance-mode level and an interrupt request.

While a transfer is running, the unit guards against register writes that would corrupt it. A refused write leaves the state untouched and raises a programming-error flag. Most error flags also terminate the running transfer. Flags clear when software writes a one to them, when the controller is initialized, or (for most of them) when the next valid transfer command is accepted.

Top module: `dma_csr_unit`

## Requirements
- R1: The control word (reg_addr 0) reads bit 4 ignore-byte-count, bit 3 maintenance mode, bit 2 interrupt enable. Bit 1 (abort) and bit 0 (init) are strobes that always read 0, as do bits 31..5. maint_mode follows bit 3.
- R2: Writing the control word with bit 0 set clears the control bits, all status flags and busy by the next cycle. ctl_clear is high for exactly that one following cycle.
- R3: While busy, a control write cannot change bits 4 and 3. If it tries to set either from 0, status bit 19 (programming error) sets. Bit 2 stays writable at any time.
- R4: A transfer command is accepted when cmd_valid and cmd_xfer are high, cmd_code lies outside 0x2D..0x3F and the unit is idle. Acceptance sets busy (status bit 31) in the next cycle and clears every sticky flag except bit 4 (invalid map) and bit 3 (error confirmation).
- R5: A transfer command arriving while busy, or a ld_wr pulse while busy with ignore-byte-count 0, sets status bit 19 and leaves busy unchanged.
- R6: While busy, ev_end or ev_ovf with ignore-byte-count 0 ends the transfer: busy clears and status bit 13 (done) sets, with bit 12 left clear.
- R7: With ignore-byte-count 1, ev_ovf does not end the transfer. With interrupt enable also set, irq is high for the one cycle after each overflow.
- R8: Error events set their flags one cycle later: ev_ovr and ev_und set bit 11, ev_wcu bit 10, ev_wcl bit 9, ev_exc bit 7, ev_im bit 4, ev_ers bit 3, ev_nrs bit 1. Any of them while busy aborts the transfer: busy clears, bits 13 and 12 set, and abort_req pulses for one cycle.
- R9: Writing control bit 1 while busy aborts the transfer exactly as in R8. Writing it while idle changes no status bit.
- R10: A cmd_valid with cmd_code in 0x2D..0x3F sets status bit 8 (missed transfer), which aborts a running transfer.
- R11: Writing a one to a sticky status bit clears it, and writing zero leaves it alone. If a set event and a write-one-to-clear hit the same bit in the same cycle, the set wins. ev_crd sets bit 29. ev_ned sets bits 18 and 17 and does not abort.
- R12: Status bit 16 is the live OR of the attn inputs and has no memory.
- R13: irq equals interrupt enable ANDed with the OR of status bits 19, 18, 16, 13, 12 and the overflow pulse of R7. Clearing interrupt enable drops irq in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| ld_wr | input | 1 | Software is writing an address, byte-count or map register |
| cmd_valid | input | 1 | A command code has been received |
| cmd_code | input | CMD_W | Received command code |
| cmd_xfer | input | 1 | The received command is a data transfer |
| ev_end | input | 1 | Normal end of transfer |
| ev_ovf | input | 1 | Byte counter overflow |
| ev_ovr | input | 1 | Buffer overflow during read |
| ev_und | input | 1 | Buffer underflow during write or write check |
| ev_wcu | input | 1 | Write-check compare error, upper byte |
| ev_wcl | input | 1 | Write-check compare error, lower byte |
| ev_exc | input | 1 | Drive exception |
| ev_nrs | input | 1 | No response from memory |
| ev_ers | input | 1 | Error confirmation from memory |
| ev_im | input | 1 | Invalid map entry with bytes remaining |
| ev_crd | input | 1 | Memory returned corrected data |
| ev_ned | input | 1 | Nonexistent drive addressed |
| attn | input | N_ATTN | Drive attention lines |
| busy | output | 1 | Transfer in progress |
| abort_req | output | 1 | One-cycle abort request to the datapath |
| ctl_clear | output | 1 | One-cycle controller clear after init |
| maint_mode | output | 1 | Maintenance mode level |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check on every cycle that busy write protection holds for the two interlocked control bits, that any error while busy ends the transfer with an abort pulse, and that an overflow under ignore-byte-count keeps the transfer alive. They also check that init empties the flag store, that a write-one-to-clear without a competing set always empties its bits, and that irq stays low without interrupt enable. Only the bench scenarios show the full bit layout of both words: the exact flag each event sets, which flags survive a new command, the refused-write bookkeeping, the single-cycle overflow interrupt, and the set-over-clear priority.

// File: rtl/dma_csr_pkg.sv
// Package: bit positions and masks shared by the transfer register unit.
// Assumes a 32-bit status word and a 5-bit control field at the bottom of the control word.
package dma_csr_pkg;

    localparam int WORD_W   = 32;
    localparam int CTL_W    = 5;

    // control field positions
    localparam int CB_IBC   = 4;
    localparam int CB_MNT   = 3;
    localparam int CB_IEN   = 2;
    localparam int CB_ABT   = 1;
    localparam int CB_INI   = 0;

    // status field positions
    localparam int SB_BUSY  = 31;
    localparam int SB_CRD   = 29;
    localparam int SB_PGE   = 19;
    localparam int SB_NED   = 18;
    localparam int SB_CPE   = 17;
    localparam int SB_ATN   = 16;
    localparam int SB_DONE  = 13;
    localparam int SB_ABTD  = 12;
    localparam int SB_LATE  = 11;
    localparam int SB_WCU   = 10;
    localparam int SB_WCL   = 9;
    localparam int SB_MISS  = 8;
    localparam int SB_EXC   = 7;
    localparam int SB_MAP   = 4;
    localparam int SB_ECF   = 3;
    localparam int SB_NRSP  = 1;

    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    // every flag that is held until cleared
    localparam logic [WORD_W-1:0] STICKY_MASK =
        (ONE << SB_CRD) | (ONE << SB_PGE) | (ONE << SB_NED) | (ONE << SB_CPE) |
        (ONE << SB_DONE) | (ONE << SB_ABTD) | (ONE << SB_LATE) | (ONE << SB_WCU) |
        (ONE << SB_WCL) | (ONE << SB_MISS) | (ONE << SB_EXC) | (ONE << SB_MAP) |
        (ONE << SB_ECF) | (ONE << SB_NRSP);

    // flags that survive acceptance of a new transfer command
    localparam logic [WORD_W-1:0] KEEP_ON_START = (ONE << SB_MAP) | (ONE << SB_ECF);

    // flags whose setting terminates a running transfer
    localparam logic [WORD_W-1:0] ABORT_MASK =
        (ONE << SB_LATE) | (ONE << SB_WCU) | (ONE << SB_WCL) | (ONE << SB_MISS) |
        (ONE << SB_EXC) | (ONE << SB_MAP) | (ONE << SB_ECF) | (ONE << SB_NRSP);

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_STS = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/dma_csr_ctl.sv
// Module: control register with busy interlock.
// Holds ignore-byte-count, maintenance mode and interrupt enable; decodes the
// abort and init strobes. Assumes busy is the registered transfer state.
module dma_csr_ctl
    import dma_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [CTL_W-1:0] wdata,
    input  logic             busy,
    output logic             init_req,
    output logic             abort_wr,
    output logic             ibc,
    output logic             mmm,
    output logic             ien,
    output logic             refuse_pge,
    output logic             ctl_clear,
    output logic [WORD_W-1:0] ctl_rdata
);

    logic ibc_q, mmm_q, ien_q, clr_q;

    // strobe decode: init overrides abort
    always_comb begin
        init_req   = wr_ctl & wdata[CB_INI];
        abort_wr   = wr_ctl & wdata[CB_ABT] & ~wdata[CB_INI];
        refuse_pge = wr_ctl & ~wdata[CB_INI] & busy &
                     ((wdata[CB_IBC] & ~ibc_q) | (wdata[CB_MNT] & ~mmm_q));
    end

    // control bit storage with the busy interlock on IBC and maintenance mode
    always_ff @(posedge clk) begin
        if (!rst_n || init_req) begin
            ibc_q <= 1'b0;
            mmm_q <= 1'b0;
            ien_q <= 1'b0;
        end else if (wr_ctl) begin
            ien_q <= wdata[CB_IEN];
            if (!busy) begin
                ibc_q <= wdata[CB_IBC];
                mmm_q <= wdata[CB_MNT];
            end
        end
    end

    // one-cycle clear pulse following an init write
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= init_req;
    end

    assign ibc       = ibc_q;
    assign mmm       = mmm_q;
    assign ien       = ien_q;
    assign ctl_clear = clr_q;
    assign ctl_rdata = {{(WORD_W-CTL_W){1'b0}}, ibc_q, mmm_q, ien_q, 2'b00};

    // R3: interlocked bits hold while busy
    p_refuse_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && busy && !init_req) |=> ($stable(ibc_q) && $stable(mmm_q)));

    // R2: init leaves every control bit clear and raises the clear pulse
    p_init_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (!ibc_q && !mmm_q && !ien_q && clr_q));

endmodule

// File: rtl/dma_csr_seq.sv
// Module: transfer sequencer.
// Tracks busy, detects normal end and abort, reports command interlock errors
// and produces the abort pulse and the overflow interrupt pulse.
// Assumes err_hit already reflects every abort-class flag being set this cycle.
module dma_csr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic init_req,
    input  logic cmd_take,
    input  logic ld_wr,
    input  logic ibc,
    input  logic abort_wr,
    input  logic err_hit,
    input  logic ev_end,
    input  logic ev_ovf,
    output logic busy,
    output logic start_ok,
    output logic done_set,
    output logic abort_set,
    output logic seq_pge,
    output logic abort_req,
    output logic ovf_irq
);

    logic busy_q, abt_q, ovf_q;
    logic abort_now, end_now;

    // termination and start decisions for this cycle
    always_comb begin
        abort_now = busy_q & (err_hit | abort_wr);
        end_now   = busy_q & ~abort_now & (ev_end | (ev_ovf & ~ibc));
        start_ok  = cmd_take & ~busy_q;
        done_set  = abort_now | end_now;
        abort_set = abort_now;
        seq_pge   = busy_q & (cmd_take | (ld_wr & ~ibc));
    end

    // busy state
    always_ff @(posedge clk) begin
        if (!rst_n || init_req)        busy_q <= 1'b0;
        else if (start_ok)             busy_q <= 1'b1;
        else if (abort_now || end_now) busy_q <= 1'b0;
    end

    // one-cycle abort request and overflow interrupt pulses
    always_ff @(posedge clk) begin
        if (!rst_n || init_req) begin
            abt_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            abt_q <= abort_now;
            ovf_q <= busy_q & ev_ovf & ibc;
        end
    end

    assign busy      = busy_q;
    assign abort_req = abt_q;
    assign ovf_irq   = ovf_q;

    // R8: any error while busy ends the transfer with an abort pulse
    p_err_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && err_hit && !init_req) |=> (!busy_q && abt_q));

    // R7: overflow with ignore-byte-count keeps the transfer alive
    p_ibc_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && ibc && ev_ovf && !ev_end && !err_hit && !abort_wr && !init_req)
        |=> busy_q);

    // R6: normal end drops busy without an abort pulse
    p_norm_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && ev_end && !err_hit && !abort_wr && !init_req) |=> (!busy_q && !abt_q));

endmodule

// File: rtl/dma_csr_flags.sv
// Module: sticky status flag store.
// Applies set events, write-one-to-clear, clear-on-start and init. Set wins
// over any clear in the same cycle except init.
module dma_csr_flags
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              start_ok,
    input  logic [WORD_W-1:0] set_vec,
    input  logic [WORD_W-1:0] w1c_vec,
    output logic [WORD_W-1:0] flags
);

    logic [WORD_W-1:0] q;
    logic [WORD_W-1:0] clr_vec;

    // combine every clear source for this cycle
    always_comb begin
        clr_vec = w1c_vec & STICKY_MASK;
        if (start_ok) clr_vec = clr_vec | (STICKY_MASK & ~KEEP_ON_START);
    end

    // flag update, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n || init_req) q <= '0;
        else                    q <= ((q & ~clr_vec) | set_vec) & STICKY_MASK;
    end

    assign flags = q;

    // R2: init empties the store
    p_init_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (q == '0));

    // R11: a written one without a competing set clears its bit
    p_w1c_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !init_req |=> ((q & $past(w1c_vec & STICKY_MASK & ~set_vec)) == '0));

endmodule

// File: rtl/dma_csr_unit.sv
// Module: transfer control/status register unit (top).
// Decodes the register port, gathers datapath events into flag set vectors,
// and drives the read mux and interrupt request. Assumes single-cycle event
// pulses from a datapath on the same clock.
module dma_csr_unit
    import dma_csr_pkg::*;
#(
    parameter int CMD_W   = 6,
    parameter int N_ATTN  = 8,
    parameter int ILL_LO  = 'h2D,
    parameter int ILL_HI  = 'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              ld_wr,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              cmd_xfer,
    input  logic              ev_end,
    input  logic              ev_ovf,
    input  logic              ev_ovr,
    input  logic              ev_und,
    input  logic              ev_wcu,
    input  logic              ev_wcl,
    input  logic              ev_exc,
    input  logic              ev_nrs,
    input  logic              ev_ers,
    input  logic              ev_im,
    input  logic              ev_crd,
    input  logic              ev_ned,
    input  logic [N_ATTN-1:0] attn,
    output logic              busy,
    output logic              abort_req,
    output logic              ctl_clear,
    output logic              maint_mode,
    output logic              irq
);

    localparam logic [CMD_W-1:0] CODE_LO = CMD_W'(ILL_LO);
    localparam logic [CMD_W-1:0] CODE_HI = CMD_W'(ILL_HI);

    logic              wr_ctl, wr_sts;
    logic              init_req, abort_wr, ibc, ien, refuse_pge;
    logic              illegal, cmd_take, err_hit, attn_any;
    logic              start_ok, done_set, abort_set, seq_pge, ovf_irq;
    logic [WORD_W-1:0] ctl_rdata, flags, set_vec, w1c_vec, err_vec;

    // register port decode
    always_comb begin
        wr_ctl   = reg_wr & (reg_sel_e'(reg_addr) == SEL_CTL);
        wr_sts   = reg_wr & (reg_sel_e'(reg_addr) == SEL_STS);
        w1c_vec  = wr_sts ? reg_wdata : '0;
        illegal  = cmd_valid & (cmd_code >= CODE_LO) & (cmd_code <= CODE_HI);
        cmd_take = cmd_valid & cmd_xfer & ~illegal;
        attn_any = |attn;
    end

    // abort-class events, kept apart so the sequencer sees them before registering
    always_comb begin
        err_vec = '0;
        err_vec[SB_LATE] = ev_ovr | ev_und;
        err_vec[SB_WCU]  = ev_wcu;
        err_vec[SB_WCL]  = ev_wcl;
        err_vec[SB_MISS] = illegal;
        err_vec[SB_EXC]  = ev_exc;
        err_vec[SB_MAP]  = ev_im;
        err_vec[SB_ECF]  = ev_ers;
        err_vec[SB_NRSP] = ev_nrs;
        err_hit = |(err_vec & ABORT_MASK);
    end

    // full set vector for the flag store
    always_comb begin
        set_vec = err_vec;
        set_vec[SB_CRD]  = ev_crd;
        set_vec[SB_PGE]  = refuse_pge | seq_pge;
        set_vec[SB_NED]  = ev_ned;
        set_vec[SB_CPE]  = ev_ned;
        set_vec[SB_DONE] = done_set;
        set_vec[SB_ABTD] = abort_set;
    end

    dma_csr_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl     (wr_ctl),
        .wdata      (reg_wdata[CTL_W-1:0]),
        .busy       (busy),
        .init_req   (init_req),
        .abort_wr   (abort_wr),
        .ibc        (ibc),
        .mmm        (maint_mode),
        .ien        (ien),
        .refuse_pge (refuse_pge),
        .ctl_clear  (ctl_clear),
        .ctl_rdata  (ctl_rdata)
    );

    dma_csr_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_req  (init_req),
        .cmd_take  (cmd_take),
        .ld_wr     (ld_wr),
        .ibc       (ibc),
        .abort_wr  (abort_wr),
        .err_hit   (err_hit),
        .ev_end    (ev_end),
        .ev_ovf    (ev_ovf),
        .busy      (busy),
        .start_ok  (start_ok),
        .done_set  (done_set),
        .abort_set (abort_set),
        .seq_pge   (seq_pge),
        .abort_req (abort_req),
        .ovf_irq   (ovf_irq)
    );

    dma_csr_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .start_ok (start_ok),
        .set_vec  (set_vec),
        .w1c_vec  (w1c_vec),
        .flags    (flags)
    );

    // read mux and interrupt level
    always_comb begin
        if (reg_sel_e'(reg_addr) == SEL_CTL) begin
            reg_rdata = ctl_rdata;
        end else begin
            reg_rdata = flags;
            reg_rdata[SB_BUSY] = busy;
            reg_rdata[SB_ATN]  = attn_any;
        end
        irq = ien & (flags[SB_PGE] | flags[SB_NED] | attn_any |
                     flags[SB_DONE] | flags[SB_ABTD] | ovf_irq);
    end

    // R13: no interrupt without interrupt enable
    p_irq_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    // R4: an accepted command makes the unit busy
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && !busy && !init_req) |=> busy);

endmodule

// File: tb/dma_csr_unit_tb.sv
module dma_csr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ld_wr = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_code = '0;
    logic        cmd_xfer = 1'b0;
    logic [11:0] ev = '0;
    logic [7:0]  attn = '0;
    logic        busy, abort_req, ctl_clear, maint_mode, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    dma_csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ld_wr(ld_wr),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_xfer(cmd_xfer),
        .ev_end(ev[0]), .ev_ovf(ev[1]), .ev_ovr(ev[2]), .ev_und(ev[3]),
        .ev_wcu(ev[4]), .ev_wcl(ev[5]), .ev_exc(ev[6]), .ev_nrs(ev[7]),
        .ev_ers(ev[8]), .ev_im(ev[9]), .ev_crd(ev[10]), .ev_ned(ev[11]),
        .attn(attn), .busy(busy), .abort_req(abort_req), .ctl_clear(ctl_clear),
        .maint_mode(maint_mode), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input int idx);
        ev[idx] = 1'b1;
        tick();
        ev[idx] = 1'b0;
    endtask

    task automatic cmd(input logic [5:0] code, input logic xf);
        cmd_valid = 1'b1; cmd_code = code; cmd_xfer = xf;
        tick();
        cmd_valid = 1'b0; cmd_xfer = 1'b0;
    endtask

    task automatic clear_all();
        wr(1'b1, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R2 reset ctl", v, 32'h0);
        rd(1'b1, v); chk("R2 reset status", v, 32'h0);
        chk("R2 reset busy/irq/clear", {busy, irq, ctl_clear, abort_req}, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        wr(1'b0, 32'hFFFF_FFFE);
        rd(1'b0, v); chk("R1 ctl layout", v, 32'h0000_001C);
        chk("R1 maint level", {31'b0, maint_mode}, 32'h1);
        wr(1'b0, 32'h0);
        rd(1'b0, v); chk("R1 ctl cleared", v, 32'h0);
    endtask

    task automatic t_start_and_interlock();
        logic [31:0] v;
        pulse(9); pulse(10);
        rd(1'b1, v); chk("R8 im and R11 crd idle", v, 32'h2000_0010);
        cmd(6'h05, 1'b1);
        rd(1'b1, v); chk("R4 start keeps map flag only", v, 32'h8000_0010);
        wr(1'b0, 32'h18);
        rd(1'b0, v); chk("R3 refused ctl bits", v, 32'h0);
        rd(1'b1, v); chk("R3 pge on refused write", v, 32'h8008_0010);
        wr(1'b1, 32'h0008_0010);
        rd(1'b1, v); chk("R11 w1c clears two flags", v, 32'h8000_0000);
        cmd(6'h07, 1'b1);
        rd(1'b1, v); chk("R5 start while busy", v, 32'h8008_0000);
        wr(1'b1, 32'h0008_0000);
        ld_wr = 1'b1; tick(); ld_wr = 1'b0;
        rd(1'b1, v); chk("R5 load while busy", v, 32'h8008_0000);
        wr(1'b1, 32'h0008_0000);
        wr(1'b0, 32'h04);
        rd(1'b0, v); chk("R3 ie writable while busy", v, 32'h04);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_end();
        logic [31:0] v;
        pulse(0);
        rd(1'b1, v); chk("R6 end sets done", v, 32'h0000_2000);
        clear_all();
        cmd(6'h05, 1'b1);
        pulse(1);
        rd(1'b1, v); chk("R6 overflow ends", v, 32'h0000_2000);
        clear_all();
    endtask

    task automatic t_ibc();
        logic [31:0] v;
        wr(1'b0, 32'h14);
        cmd(6'h05, 1'b1);
        pulse(1);
        chk("R7 overflow keeps busy", {31'b0, busy}, 32'h1);
        chk("R7 overflow irq pulse", {31'b0, irq}, 32'h1);
        tick();
        chk("R7 irq pulse ends", {31'b0, irq}, 32'h0);
        pulse(0);
        chk("R13 irq on done", {31'b0, irq}, 32'h1);
        wr(1'b0, 32'h0);
        chk("R13 irq drops with ie", {31'b0, irq}, 32'h0);
        rd(1'b1, v); chk("R6 done after ibc end", v, 32'h0000_2000);
        clear_all();
    endtask

    task automatic t_errors();
        logic [31:0] v;
        logic [31:0] exp_bit [2:9];
        exp_bit[2] = 32'h800; exp_bit[3] = 32'h800; exp_bit[4] = 32'h400;
        exp_bit[5] = 32'h200; exp_bit[6] = 32'h080; exp_bit[7] = 32'h002;
        exp_bit[8] = 32'h008; exp_bit[9] = 32'h010;
        for (int i = 2; i <= 9; i++) begin
            cmd(6'h05, 1'b1);
            pulse(i);
            rd(1'b1, v); chk("R8 error flag and abort", v, exp_bit[i] | 32'h3000);
            chk("R8 abort pulse", {30'b0, busy, abort_req}, 32'h1);
            tick();
            chk("R8 abort pulse one cycle", {31'b0, abort_req}, 32'h0);
            clear_all();
        end
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        cmd(6'h05, 1'b1);
        cmd(6'h2D, 1'b0);
        rd(1'b1, v); chk("R10 low bound aborts", v, 32'h0000_3100);
        clear_all();
        cmd(6'h3F, 1'b1);
        rd(1'b1, v); chk("R10 high bound idle", v, 32'h0000_0100);
        clear_all();
        cmd(6'h2C, 1'b1);
        chk("R4 code below range accepted", {31'b0, busy}, 32'h1);
        pulse(0);
        clear_all();
    endtask

    task automatic t_ned_attn();
        logic [31:0] v;
        pulse(11);
        rd(1'b1, v); chk("R11 ned sets two bits", v, 32'h0006_0000);
        wr(1'b0, 32'h04);
        chk("R13 irq on ned", {31'b0, irq}, 32'h1);
        clear_all();
        chk("R13 irq clear after w1c", {31'b0, irq}, 32'h0);
        attn = 8'h04;
        rd(1'b1, v); chk("R12 attention live", v, 32'h0001_0000);
        chk("R13 irq on attention", {31'b0, irq}, 32'h1);
        attn = 8'h00;
        rd(1'b1, v); chk("R12 attention not sticky", v, 32'h0);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_abort_bit();
        logic [31:0] v;
        wr(1'b0, 32'h02);
        rd(1'b1, v); chk("R9 idle abort no effect", v, 32'h0);
        cmd(6'h05, 1'b1);
        wr(1'b0, 32'h02);
        rd(1'b1, v); chk("R9 abort bit stops", v, 32'h0000_3000);
        chk("R9 abort pulse", {31'b0, abort_req}, 32'h1);
        clear_all();
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse(10);
        ev[10] = 1'b1;
        wr(1'b1, 32'h2000_0000);
        ev[10] = 1'b0;
        rd(1'b1, v); chk("R11 set beats clear", v, 32'h2000_0000);
        wr(1'b1, 32'h0);
        rd(1'b1, v); chk("R11 zero write ignored", v, 32'h2000_0000);
        wr(1'b1, 32'h2000_0000);
        rd(1'b1, v); chk("R11 clear alone", v, 32'h0);
    endtask

    task automatic t_init();
        logic [31:0] v;
        wr(1'b0, 32'h1C);
        cmd(6'h05, 1'b1);
        pulse(10);
        wr(1'b0, 32'h01);
        rd(1'b0, v); chk("R2 init ctl", v, 32'h0);
        rd(1'b1, v); chk("R2 init status", v, 32'h0);
        chk("R2 init clear pulse", {29'b0, busy, maint_mode, ctl_clear}, 32'h1);
        tick();
        chk("R2 clear pulse one cycle", {31'b0, ctl_clear}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_start_and_interlock();
        t_end();
        t_ibc();
        t_errors();
        t_illegal();
        t_ned_attn();
        t_abort_bit();
        t_set_wins();
        t_init();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule